// File: doc/BRIEF.md
# Root Hub Downstream Port Status Register

This block keeps the status and control state of a single downstream port on a USB host controller root hub. Software sees it as one 32-bit register. A read returns the live port state and the latched change flags. A write carries one-shot command bits, where a 1 triggers an action and a 0 does nothing. The block tracks port power, connection, enable, suspend, reset signalling and overcurrent. It applies either global or per-port power switching and refuses commands that the current port state does not allow.

The hub-level register logic supplies the global power set and clear strobes. A reset timer outside the block supplies a completion pulse. The connect indication is a level input from the line monitor. The change flags are cleared by writing 1s on a separate change-clear strobe. A resume request leaves the block as a one-cycle pulse.

Register layout, with bits numbered from 0 at the LSB. Read bits: 0 connected, 1 enabled, 2 suspended, 3 overcurrent indicator, 4 reset active, 8 power on, 16 connect change flag, 20 reset change flag. Every other bit reads 0. Write command bits (valid with `wr_en_i`): 0 clear-enable, 1 set-enable, 2 set-suspend, 3 clear-suspend (resume), 4 set-reset, 8 set-port-power, 9 clear-port-power. Change-clear bits (valid with `chg_clr_i`): 16 and 20.

Top module: `rh_port_status`

## Requirements
- R1: After reset, the register reads 0x00000000, or 0x00000100 when `no_pwr_sw_i` is 1.
- R2: The port power command bits (8 set, 9 clear) change power only when `pwr_mode_i`=1 and `pwr_mask_i`=1. The global strobes change power only in the other three combinations. Every command takes effect on the next read after its clock edge.
- R3: When a set and a clear of power reach the port in the same cycle through the enabled channel, power ends at 0.
- R4: `oc_i` high at a clock edge clears power. Bit 3 reads `oc_i` live when `oc_report_i`=1, and reads 0 otherwise.
- R5: One cycle after power reads 0, bits 0 to 4 read 0.
- R6: Writing 1 to bit 4 sets reset-active only when the port is connected. When the port is not connected, the write sets the connect change flag (bit 16) and leaves bit 4 at 0.
- R7: A `rst_done_i` pulse while reset is active clears bit 4, sets bit 20 and sets bit 1, all at the same edge.
- R8: Writing 1 to bit 3 pulses `resume_o` for exactly one cycle and clears suspend, but only when suspend reads 1. Set-suspend (bit 2) acts only when the port is enabled.
- R9: A write of all zeros leaves the register unchanged.
- R10: With `no_pwr_sw_i`=1, power reads 1 regardless of commands and overcurrent.
- R11: The connect change flag sets when the powered connect state differs from `conn_i`. A change flag is cleared by a 1 on `chg_clr_i`. A set event in the same cycle wins over the clear.
- R12: Bits 5, 6 and 7 always read 0.
- R13: Set-enable (bit 1) acts only when the port is connected. Clear-enable (bit 0) clears the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_mode_i | input | 1 | 0 global switching, 1 per-port switching |
| pwr_mask_i | input | 1 | Per-port control mask bit for this port |
| no_pwr_sw_i | input | 1 | Power switching not supported; power reads 1 |
| oc_report_i | input | 1 | Per-port overcurrent reporting enabled |
| oc_i | input | 1 | Overcurrent input |
| conn_i | input | 1 | Device connect level |
| rst_done_i | input | 1 | Reset timer completion pulse |
| gpwr_set_i | input | 1 | Global power-on strobe |
| gpwr_clr_i | input | 1 | Global power-off strobe |
| wr_en_i | input | 1 | Command write strobe |
| chg_clr_i | input | 1 | Change-flag clear strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register read value |
| resume_o | output | 1 | One-cycle resume request |

## Verification
On every cycle, the assertions check that overcurrent and the enabled clear channel remove power, and that an unpowered port has no link state one cycle later. They also check that a refused reset raises the connect change flag, that a reset completion lands in a single edge, that a resume only follows a suspended state, and that a set event wins over a flag clear. The masking of the power channels across all mode and mask combinations, zero-write neutrality and the configuration-dependent read values are shown only by the bench's scenarios. Those scenarios are an exhaustive sweep of mode, mask, start state and command, followed by directed sequences.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_CHG = 2;
  localparam int B_CCS   = 0;   // connected / clear-enable cmd
  localparam int B_PES   = 1;   // enabled / set-enable cmd
  localparam int B_PSS   = 2;   // suspended / set-suspend cmd
  localparam int B_OCI   = 3;   // overcurrent / clear-suspend cmd
  localparam int B_PRS   = 4;   // reset active / set-reset cmd
  localparam int B_PPS   = 8;   // power / set-power cmd
  localparam int B_CPP   = 9;   // clear-power cmd
  localparam int B_CSC   = 16;  // connect change
  localparam int B_PRSC  = 20;  // reset change
  localparam int CHG_CONN = 0;
  localparam int CHG_RST  = 1;
endpackage

// File: rtl/rh_power_ctl.sv
module rh_power_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic psm_i,
  input  logic mask_i,
  input  logic unsup_i,
  input  logic oc_i,
  input  logic gset_i,
  input  logic gclr_i,
  input  logic pset_i,
  input  logic pclr_i,
  output logic pwr_o
);
  logic pwr_q, port_mode, set_sel, clr_sel;

  assign port_mode = psm_i & mask_i;
  assign set_sel   = port_mode ? pset_i : gset_i;
  assign clr_sel   = port_mode ? pclr_i : gclr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pwr_q <= 1'b0;
    else if (oc_i || clr_sel)   pwr_q <= 1'b0;  // clear wins
    else if (set_sel)           pwr_q <= 1'b1;
  end

  assign pwr_o = pwr_q | unsup_i;

  assert_oc_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |=> !pwr_q);
  assert_glob_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gclr_i && !(psm_i && mask_i)) |=> !pwr_q);
endmodule

// File: rtl/rh_link_state.sv
module rh_link_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  input  logic conn_i,
  input  logic set_rst_i,
  input  logic set_en_i,
  input  logic clr_en_i,
  input  logic set_susp_i,
  input  logic clr_susp_i,
  input  logic rst_done_i,
  output logic conn_o,
  output logic en_o,
  output logic susp_o,
  output logic prs_o,
  output logic resume_o,
  output logic csc_set_o,
  output logic prsc_set_o
);
  logic conn_q, en_q, susp_q, prs_q, resume_q;
  logic conn_d, en_d, susp_d, prs_d, resume_go, rst_fin;

  assign conn_d    = pwr_i & conn_i;
  assign resume_go = clr_susp_i & susp_q;
  assign rst_fin   = rst_done_i & prs_q;

  always_comb begin
    if (!pwr_i || !conn_d)      prs_d = 1'b0;
    else if (rst_done_i)        prs_d = 1'b0;
    else if (set_rst_i)         prs_d = 1'b1;
    else                        prs_d = prs_q;

    if (!pwr_i || !conn_d)      en_d = 1'b0;
    else if (clr_en_i)          en_d = 1'b0;
    else if (set_en_i && conn_q) en_d = 1'b1;
    else if (rst_fin)           en_d = 1'b1;
    else                        en_d = en_q;

    if (!pwr_i || !en_d)        susp_d = 1'b0;
    else if (resume_go)         susp_d = 1'b0;
    else if (set_susp_i && en_q) susp_d = 1'b1;
    else                        susp_d = susp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0; en_q <= 1'b0; susp_q <= 1'b0; prs_q <= 1'b0; resume_q <= 1'b0;
    end else begin
      conn_q   <= conn_d;
      en_q     <= en_d;
      susp_q   <= susp_d;
      prs_q    <= prs_d;
      resume_q <= resume_go;
    end
  end

  // disconnected reset request is reported, not acted on
  assign csc_set_o  = (pwr_i && (conn_i != conn_q)) || (set_rst_i && !conn_q);
  assign prsc_set_o = rst_fin;
  assign conn_o     = conn_q;
  assign en_o       = en_q;
  assign susp_o     = susp_q;
  assign prs_o      = prs_q;
  assign resume_o   = resume_q;

  assert_unpowered_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |=> !(conn_q || en_q || susp_q || prs_q));
  assert_resume_needs_susp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> ($past(susp_q) && $past(clr_susp_i)));
  assert_resume_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> !susp_q);
endmodule

// File: rtl/rh_change_flags.sv
module rh_change_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end

    assert_set_beats_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
  import rh_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_mode_i,
  input  logic             pwr_mask_i,
  input  logic             no_pwr_sw_i,
  input  logic             oc_report_i,
  input  logic             oc_i,
  input  logic             conn_i,
  input  logic             rst_done_i,
  input  logic             gpwr_set_i,
  input  logic             gpwr_clr_i,
  input  logic             wr_en_i,
  input  logic             chg_clr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             resume_o
);
  logic [REG_W-1:0]   cmd;
  logic               pwr, conn, en, susp, prs, csc_set, prsc_set;
  logic [NUM_CHG-1:0] chg_set, chg_clr, chg;
  logic               unused_wdata;

  assign cmd = wr_en_i ? wdata_i : '0;

  rh_power_ctl u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .psm_i   (pwr_mode_i),
    .mask_i  (pwr_mask_i),
    .unsup_i (no_pwr_sw_i),
    .oc_i    (oc_i),
    .gset_i  (gpwr_set_i),
    .gclr_i  (gpwr_clr_i),
    .pset_i  (cmd[B_PPS]),
    .pclr_i  (cmd[B_CPP]),
    .pwr_o   (pwr)
  );

  rh_link_state u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_i      (pwr),
    .conn_i     (conn_i),
    .set_rst_i  (cmd[B_PRS]),
    .set_en_i   (cmd[B_PES]),
    .clr_en_i   (cmd[B_CCS]),
    .set_susp_i (cmd[B_PSS]),
    .clr_susp_i (cmd[B_OCI]),
    .rst_done_i (rst_done_i),
    .conn_o     (conn),
    .en_o       (en),
    .susp_o     (susp),
    .prs_o      (prs),
    .resume_o   (resume_o),
    .csc_set_o  (csc_set),
    .prsc_set_o (prsc_set)
  );

  assign chg_set[CHG_CONN] = csc_set;
  assign chg_set[CHG_RST]  = prsc_set;
  assign chg_clr[CHG_CONN] = chg_clr_i & wdata_i[B_CSC];
  assign chg_clr[CHG_RST]  = chg_clr_i & wdata_i[B_PRSC];

  rh_change_flags #(.N(NUM_CHG)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chg_set),
    .clr_i  (chg_clr),
    .flag_o (chg)
  );

  always_comb begin
    rdata_o         = '0;
    rdata_o[B_CCS]  = conn;
    rdata_o[B_PES]  = en;
    rdata_o[B_PSS]  = susp;
    rdata_o[B_OCI]  = oc_i & oc_report_i;
    rdata_o[B_PRS]  = prs;
    rdata_o[B_PPS]  = pwr;
    rdata_o[B_CSC]  = chg[CHG_CONN];
    rdata_o[B_PRSC] = chg[CHG_RST];
  end

  assign unused_wdata = ^{cmd[REG_W-1:B_CPP+1], cmd[B_PPS-1:B_PRS+1]};

  assert_bad_reset_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[B_PRS] && !rdata_o[B_CCS]) |=> (rdata_o[B_CSC] && !rdata_o[B_PRS]));
  assert_reset_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_done_i && rdata_o[B_PRS]) |=> (!rdata_o[B_PRS] && rdata_o[B_PRSC]));
  assert_reserved_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:5] == 3'b000);
endmodule

// File: tb/rh_port_status_bench.sv
module rh_port_status_bench;
  localparam int CLK_HALF = 2500;  // ps, 200 MHz
  timeunit 1ps; timeprecision 1ps;

  logic clk = 0, rst_ni = 0;
  logic pwr_mode = 0, pwr_mask = 0, no_pwr_sw = 0, oc_report = 0, oc = 0, conn = 0;
  logic rst_done = 0, gset = 0, gclr = 0, wr_en = 0, chg_clr = 0;
  logic [31:0] wdata = 0, rdata, snap;
  logic resume;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_HALF) clk = ~clk;

  rh_port_status u_rh_port_status (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_mode_i(pwr_mode), .pwr_mask_i(pwr_mask),
    .no_pwr_sw_i(no_pwr_sw), .oc_report_i(oc_report), .oc_i(oc), .conn_i(conn),
    .rst_done_i(rst_done), .gpwr_set_i(gset), .gpwr_clr_i(gclr), .wr_en_i(wr_en),
    .chg_clr_i(chg_clr), .wdata_i(wdata), .rdata_o(rdata), .resume_o(resume)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    gset = 0; gclr = 0; wr_en = 0; chg_clr = 0; rst_done = 0; wdata = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wdata = d; tick();
  endtask

  task automatic clrchg(input logic [31:0] d);
    chg_clr = 1; wdata = d; tick();
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    chk("R1 reset value", rdata, 32'h0);

    // R2 exhaustive: mode x mask x start x command
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 4; c++) begin
            bit pm, e;
            pwr_mode = m[0]; pwr_mask = k[0];
            pm = m[0] & k[0];
            gclr = 1; wr(32'h200);
            if (s == 1) begin gset = 1; wr(32'h100); end
            chk("R2 start", {31'b0, rdata[8]}, {31'b0, s[0]});
            case (c)
              0: wr(32'h100);
              1: wr(32'h200);
              2: begin gset = 1; tick(); end
              default: begin gclr = 1; tick(); end
            endcase
            e = s[0];
            if (c == 0 && pm)  e = 1;
            if (c == 1 && pm)  e = 0;
            if (c == 2 && !pm) e = 1;
            if (c == 3 && !pm) e = 0;
            chk("R2 power cmd", {31'b0, rdata[8]}, {31'b0, e});
          end

    // R3 clear wins, global then port channel
    pwr_mode = 0; pwr_mask = 0;
    gset = 1; tick();
    gset = 1; gclr = 1; tick();
    chk("R3 global set+clr", {31'b0, rdata[8]}, 32'h0);
    pwr_mode = 1; pwr_mask = 1;
    wr(32'h100);
    wr(32'h300);
    chk("R3 port set+clr", {31'b0, rdata[8]}, 32'h0);

    // powered and connected
    pwr_mode = 0; pwr_mask = 0;
    gset = 1; tick();
    conn = 1; tick();
    chk("R11 connect sets flag", rdata, 32'h0001_0101);
    clrchg(32'h0001_0000);
    chk("R11 flag cleared", rdata, 32'h0000_0101);
    conn = 0; chg_clr = 1; wdata = 32'h0001_0000; tick();
    chk("R11 set beats clear", rdata, 32'h0001_0100);
    conn = 1; tick();
    clrchg(32'h0001_0000);
    chk("R11 reconnected", rdata, 32'h0000_0101);

    // R6 legal reset, R7 completion
    wr(32'h10);
    chk("R6 reset starts", rdata, 32'h0000_0111);
    rst_done = 1; tick();
    chk("R7 reset done", rdata, 32'h0010_0103);
    clrchg(32'h0011_0000);

    // R6 illegal reset
    conn = 0; tick();
    clrchg(32'h0001_0000);
    chk("R13 disconnect drops enable", rdata, 32'h0000_0100);
    wr(32'h10);
    chk("R6 refused reset", rdata, 32'h0001_0100);
    wr(32'h2);
    chk("R13 set-enable refused", rdata[1:0], 2'b00);
    conn = 1; tick();
    clrchg(32'h0011_0000);

    // R13 / R8 enable, suspend, resume
    wr(32'h4);
    chk("R8 suspend needs enable", rdata, 32'h0000_0101);
    wr(32'h2);
    chk("R13 set-enable", rdata, 32'h0000_0103);
    wr(32'h1);
    chk("R13 clear-enable", rdata, 32'h0000_0101);
    wr(32'h2);
    wr(32'h4);
    chk("R8 suspended", rdata, 32'h0000_0107);
    wr(32'h8);
    chk("R8 resume pulse", {31'b0, resume}, 32'h1);
    chk("R8 suspend cleared", rdata, 32'h0000_0103);
    tick();
    chk("R8 pulse one cycle", {31'b0, resume}, 32'h0);
    wr(32'h8);
    chk("R8 no resume when awake", {31'b0, resume}, 32'h0);

    // R9 zero write
    snap = rdata;
    wr(32'h0);
    chk("R9 zero write", rdata, snap);
    chk("R12 reserved", {29'b0, rdata[7:5]}, 32'h0);

    // R5 power-off forcing
    wr(32'h10);
    chk("R5 pre reset active", rdata[4:0], 5'b10011);
    gclr = 1; tick();
    chk("R5 power off", {31'b0, rdata[8]}, 32'h0);
    tick();
    chk("R5 link bits cleared", {27'b0, rdata[4:0]}, 32'h0);

    // R4 overcurrent
    gset = 1; tick();
    tick();
    clrchg(32'h0011_0000);
    oc_report = 1; oc = 1; tick();
    chk("R4 indicator", {31'b0, rdata[3]}, 32'h1);
    chk("R4 power cleared", {31'b0, rdata[8]}, 32'h0);
    oc_report = 0; #1;
    chk("R4 indicator masked", {31'b0, rdata[3]}, 32'h0);
    oc = 0;
    chk("R12 reserved after oc", {29'b0, rdata[7:5]}, 32'h0);

    // R10 unsupported switching
    no_pwr_sw = 1; gclr = 1; tick();
    chk("R10 forced power", {31'b0, rdata[8]}, 32'h1);
    oc = 1; tick(); oc = 0;
    chk("R10 power despite oc", {31'b0, rdata[8]}, 32'h1);
    rst_ni = 0; #1;
    chk("R1 reset value no switching", rdata, 32'h0000_0100);
    #10 rst_ni = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule